// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects single-cycle event pulses from a metering datapath into a sticky status register. An enable mask selects which of those latched causes may pull the shared interrupt line low. The line is active low and open drain. It is modelled as a drive-low enable: `irq_drive_low` high means the pad pulls the wire low, and low means the pad releases it.

Five causes are tracked: a new waveform sample being ready, a line-voltage zero crossing, a voltage sag, the energy accumulator reaching half of its range, and the energy accumulator wrapping. Every pulse is recorded, whether its enable bit is set or not.

The host services an interrupt in two steps. It first reads the status register with a read-with-clear strobe, which returns the pending causes. That same read clears exactly the bits it returned. The host writes the enable mask through a separate write strobe and can read it back at any time. The request stays asserted for as long as at least one enabled cause is pending.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `stat_rdata` and `en_rdata` are all zero and `irq_drive_low` is low.
- R2: An `event_pulse` bit high in a cycle sets the matching status bit. The bit is visible on `stat_rdata` after the next clock edge, whatever the enable mask holds.
- R3: A set status bit stays set on later cycles until a clearing read happens.
- R4: `stat_rdata` is valid combinationally in the cycle `stat_rd_clr` is high. After that clock edge, every bit it returned is zero unless an event for that bit arrived in the same cycle.
- R5: An event pulse in the same cycle as a clearing read leaves its status bit set after the edge.
- R6: With `en_wr` high, `en_wdata` is stored in the enable mask and shows on `en_rdata` after the clock edge. With `en_wr` low, the mask holds its value.
- R7: `irq_drive_low` is high exactly when some status bit and its enable bit are both set. A pending cause whose enable bit is clear does not assert it.
- R8: The request is released as soon as no enabled status bit is set. This happens either because the pending bits were cleared by a read or because their enable bits were written to zero.
- R9: The bit positions are the same in `event_pulse`, `stat_rdata`, `en_wdata` and `en_rdata`:
  - bit 0: waveform sample ready
  - bit 1: zero crossing
  - bit 2: sag
  - bit 3: energy half-full
  - bit 4: energy wrap

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_pulse | input | 5 | One-cycle event pulses, one bit per cause |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 5 | New enable mask value |
| en_rdata | output | 5 | Current enable mask |
| stat_rd_clr | input | 1 | Read-with-clear strobe for the status register |
| stat_rdata | output | 5 | Current status bits |
| irq_drive_low | output | 1 | High when the request pad must pull the line low |

## Verification
The hardest case to reach from the ports is a fresh event landing in the very cycle a clearing read empties the register. The clear and the set then act on the same bit, or on different bits, at one edge. The vector table places an event pulse and `stat_rd_clr` in the same step, both on a bit that is already pending and on one that is not. This shows that only the returned, unrefreshed bits drop. Release of the request line by a mask write alone, with the status left pending, is also driven from the table. A directed pass walks each bit position on its own to pin down the encoding.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NUM_EVENTS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] event_pulse,
  input  logic                  en_wr,
  input  logic [NUM_EVENTS-1:0] en_wdata,
  output logic [NUM_EVENTS-1:0] en_rdata,
  input  logic                  stat_rd_clr,
  output logic [NUM_EVENTS-1:0] stat_rdata,
  output logic                  irq_drive_low
);

  logic [NUM_EVENTS-1:0] stat_q;
  logic [NUM_EVENTS-1:0] en_q;
  logic [NUM_EVENTS-1:0] stat_keep;

  // a clearing read drops what it returned; fresh pulses always win
  assign stat_keep = stat_rd_clr ? '0 : stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_keep | event_pulse;
      if (en_wr) en_q <= en_wdata;
    end
  end

  assign stat_rdata    = stat_q;
  assign en_rdata      = en_q;
  assign irq_drive_low = |(stat_q & en_q);

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_pulse) |=> ((stat_rdata & $past(event_pulse)) == $past(event_pulse))); // R2

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_clr |=> ((stat_rdata & $past(stat_rdata)) == $past(stat_rdata))); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_clr |=> ((stat_rdata & $past(stat_rdata) & ~$past(event_pulse)) == '0)); // R4

  AST_COINCIDENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_clr && (|event_pulse)) |=> ((stat_rdata & $past(event_pulse)) == $past(event_pulse))); // R5

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_rdata == $past(en_wdata))); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_rdata)); // R6

  AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata == '0 || en_rdata == '0) |-> !irq_drive_low); // R8

endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  localparam int WATCHDOG = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] event_pulse = '0;
  logic       en_wr = 1'b0;
  logic [4:0] en_wdata = '0;
  logic [4:0] en_rdata;
  logic       stat_rd_clr = 1'b0;
  logic [4:0] stat_rdata;
  logic       irq_drive_low;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .event_pulse(event_pulse),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .stat_rd_clr(stat_rd_clr), .stat_rdata(stat_rdata),
    .irq_drive_low(irq_drive_low)
  );

  // {expected stat, expected en, expected irq (state before this step),
  //  then inputs applied this step: ev, wr, wdata, rd}
  localparam logic [22:0] VEC [NV] = '{
    {5'b00000, 5'b00000, 1'b0, 5'b00001, 1'b0, 5'b00000, 1'b0}, // R1 then set
    {5'b00001, 5'b00000, 1'b0, 5'b00000, 1'b0, 5'b00000, 1'b0}, // R2 R7 disabled
    {5'b00001, 5'b00000, 1'b0, 5'b00000, 1'b1, 5'b00001, 1'b0}, // R3 sticky
    {5'b00001, 5'b00001, 1'b1, 5'b00000, 1'b0, 5'b00000, 1'b1}, // R6 R7 read
    {5'b00000, 5'b00001, 1'b0, 5'b00100, 1'b0, 5'b00000, 1'b0}, // R4 R8
    {5'b00100, 5'b00001, 1'b0, 5'b00001, 1'b0, 5'b00000, 1'b1}, // R7 masked, coincident
    {5'b00001, 5'b00001, 1'b1, 5'b00000, 1'b1, 5'b00000, 1'b0}, // R5
    {5'b00001, 5'b00000, 1'b0, 5'b11110, 1'b0, 5'b00000, 1'b0}, // R8 by mask
    {5'b11111, 5'b00000, 1'b0, 5'b00000, 1'b1, 5'b10000, 1'b0}, // R2 many
    {5'b11111, 5'b10000, 1'b1, 5'b00000, 1'b0, 5'b00000, 1'b1}, // R7
    {5'b00000, 5'b10000, 1'b0, 5'b10000, 1'b1, 5'b00000, 1'b0}, // R4
    {5'b10000, 5'b00000, 1'b0, 5'b00000, 1'b1, 5'b11111, 1'b0}, // R6
    {5'b10000, 5'b11111, 1'b1, 5'b10000, 1'b0, 5'b00000, 1'b1}, // R7
    {5'b10000, 5'b11111, 1'b1, 5'b00000, 1'b0, 5'b00000, 1'b1}, // R5
    {5'b00000, 5'b11111, 1'b0, 5'b00000, 1'b0, 5'b00000, 1'b0}  // R4 R8
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R6";
      4: return "R4";
      5: return "R7";
      6: return "R5";
      7: return "R8";
      8: return "R2";
      9: return "R7";
      10: return "R4";
      11: return "R6";
      12: return "R7";
      13: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [4:0] es, logic [4:0] ee, logic ei);
    checks++;
    if (stat_rdata !== es || en_rdata !== ee || irq_drive_low !== ei) begin
      fails++;
      $display("FAIL %s: stat=%b en=%b irq=%b expected stat=%b en=%b irq=%b",
               tag, stat_rdata, en_rdata, irq_drive_low, es, ee, ei);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 5'b0, 5'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(vec_tag(i), VEC[i][22:18], VEC[i][17:13], VEC[i][12]);
      event_pulse = VEC[i][11:7];
      en_wr       = VEC[i][6];
      en_wdata    = VEC[i][5:1];
      stat_rd_clr = VEC[i][0];
    end
    @(negedge clk);
    event_pulse = '0; en_wr = 1'b0; stat_rd_clr = 1'b0;

    // R1: reset in the middle of activity
    event_pulse = 5'b01010; en_wr = 1'b1; en_wdata = 5'b11111;
    @(negedge clk);
    event_pulse = '0; en_wr = 1'b0;
    check("R7", 5'b01010, 5'b11111, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 5'b0, 5'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 5'b0, 5'b0, 1'b0);

    // R9: each position alone, mask set to the same position
    for (int b = 0; b < 5; b++) begin
      en_wr = 1'b1; en_wdata = 5'(1 << b);
      event_pulse = 5'(1 << b);
      @(negedge clk);
      en_wr = 1'b0; event_pulse = '0;
      check("R9", 5'(1 << b), 5'(1 << b), 1'b1);
      en_wr = 1'b1; en_wdata = ~5'(1 << b);
      @(negedge clk);
      en_wr = 1'b0;
      check("R9", 5'(1 << b), ~5'(1 << b), 1'b0);
      stat_rd_clr = 1'b1;
      @(negedge clk);
      stat_rd_clr = 1'b0;
      check("R4", 5'b0, ~5'(1 << b), 1'b0);
    end

    finish_run();
  end
endmodule